// File: doc/BRIEF.md
# Polarity-Programmable Channel Input Combiner

This block produces the on/off command for a group of low-side power channels. Each channel has a parallel control pin and a data bit that the serial control interface writes. The block merges the two with a shared Boolean operator, OR or AND, to form that channel's gate enable. A board-level strap input sets whether the parallel pins count as active when high or active when low. The serial interface decodes each command and presents the block with a one-cycle strobe, the 4-bit command code and the data nibble. Two command codes select the operator. The operator then holds its value until another of those two codes arrives or a reset occurs.

A thermal shutdown input from the diagnosis unit forces its channel off at once, whatever the pin, the data bit and the operator say. The parallel pins are asynchronous to the block clock. They are converted to active-true levels and then pass through a two-flop synchronizer before they are combined.

Top module: `chan_gate_combiner`

## Requirements
- R1: While the synchronous active-low reset `rst_n` is low at a clock edge, the block clears the stored data bits to 0000 and sets the operator to OR. During reset every `gate_en` bit is 0. After reset each channel therefore follows its active pin level alone.
- R2: Pin `pin_in[n]` affects only `gate_en[n]`. A pin change that is present at one rising edge appears on `gate_en` after the second rising edge.
- R3: With `strap_hi` = 1 a pin is active when high. With `strap_hi` = 0 a pin is active when low. A strap change passes through the same two-edge synchronizer as the pins.
- R4: A strobed command with code 4'b0011 selects OR and loads `cmd_data` as the new data bits. Code 4'b1111 selects AND and loads `cmd_data` in the same way. The new values take effect after the strobe's clock edge.
- R5: Strobed codes 4'b0000, 4'b1100 and 4'b1010 change neither the data bits nor the operator, whatever `cmd_data` holds.
- R6: A strobed code that is not one of the five listed in R4 and R5 loads `cmd_data` as the data bits and keeps the operator it already had.
- R7: When no thermal shutdown is active, `gate_en[n]` = active(pin n) OP data[n], where OP is the latched OR or AND. `cmd_data[n]` drives channel n.
- R8: While `therm_off[n]` = 1, `gate_en[n]` is 0 in the same cycle, with no register delay.
- R9: When `cmd_valid` is low at a clock edge, the data bits and the operator hold their values, whatever `cmd_code` and `cmd_data` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_hi | input | 1 | Pin polarity strap: 1 active-high, 0 active-low |
| pin_in | input | 4 | Asynchronous parallel control pins, one per channel |
| cmd_valid | input | 1 | One-cycle strobe for a decoded serial command |
| cmd_code | input | 4 | Command code that accompanies the strobe |
| cmd_data | input | 4 | Data nibble that accompanies the strobe, bit n for channel n |
| therm_off | input | 4 | Per-channel thermal shutdown from the diagnosis unit |
| gate_en | output | 4 | Per-channel gate enable |

## Verification
The bench sweeps every data nibble under both operators against every pin pattern for both strap levels. Each point also gets a thermal-shutdown mask, so the sweep shows whether each channel sees only its own pin and data bit and whether OR and AND are told apart. It also shows that polarity is applied per strap level and that shutdown wins over every other input. The directed sequences that follow write a known state first. They then issue the three ignored codes, an unlisted code and an unstrobed command. All-active pins expose the stored data bits, and all-inactive pins expose the operator, so the bench can tell a lost data load from a lost operator. Separate steps check the two-edge pin latency, the reset defaults and a reset taken in the middle of a run.

// File: rtl/gcmb_pkg.sv
`timescale 1ns/1ps
// Shared types for the channel input combiner: the combining operator
// and the classification of serial command codes.
package gcmb_pkg;

    typedef enum logic {
        OP_OR  = 1'b0,
        OP_AND = 1'b1
    } comb_op_t;

    typedef enum logic [1:0] {
        ACT_NONE     = 2'd0,
        ACT_LOAD     = 2'd1,
        ACT_LOAD_OR  = 2'd2,
        ACT_LOAD_AND = 2'd3
    } cmd_act_t;

    localparam int CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_STATUS   = 4'b0000;
    localparam logic [CODE_W-1:0] CODE_LOOKBACK = 4'b1100;
    localparam logic [CODE_W-1:0] CODE_LOOP     = 4'b1010;
    localparam logic [CODE_W-1:0] CODE_SEL_OR   = 4'b0011;
    localparam logic [CODE_W-1:0] CODE_SEL_AND  = 4'b1111;

    // Map a command code to its effect on the stored channel state.
    function automatic cmd_act_t classify_code(input logic [CODE_W-1:0] code);
        cmd_act_t act;
        case (code)
            CODE_STATUS,
            CODE_LOOKBACK,
            CODE_LOOP:     act = ACT_NONE;
            CODE_SEL_OR:   act = ACT_LOAD_OR;
            CODE_SEL_AND:  act = ACT_LOAD_AND;
            default:       act = ACT_LOAD;
        endcase
        return act;
    endfunction

endpackage

// File: rtl/gcmb_pin_sync.sv
`timescale 1ns/1ps
// Polarity correction and multi-stage synchronizer for the parallel pins.
// Does: turns each raw pin level into an active-true level using the strap,
//       then passes it through STAGES flops.
// Assumes: pins and strap are asynchronous to clk; reset clears every stage,
//          so all channels read as inactive right after reset.
module gcmb_pin_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_hi,
    input  logic [WIDTH-1:0] pin_raw,
    output logic [WIDTH-1:0] act_sync
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] act_raw;
    logic [WIDTH-1:0] stage_q [STAGES];

    // Convert pin levels to active-true before crossing into the clock domain.
    always_comb begin
        act_raw = strap_hi ? pin_raw : ~pin_raw;
    end

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First capture flop of the synchronizer chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= act_raw;
                end
            end else begin : g_next
                // Later flops of the chain, each fed by the previous stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign act_sync = stage_q[LAST];

endmodule

// File: rtl/gcmb_cmd_reg.sv
`timescale 1ns/1ps
// Command state register for the channel input combiner.
// Does: holds the per-channel data bits and the sticky combining operator,
//       updated only by a strobed command from the serial decoder.
// Assumes: cmd_valid is a single-cycle strobe in the clk domain.
module gcmb_cmd_reg
    import gcmb_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [N_CH-1:0]   cmd_data,
    output logic [N_CH-1:0]   data_q,
    output comb_op_t          op_q
);

    cmd_act_t act;

    // Decode the effect of the current command code.
    always_comb begin
        act = classify_code(cmd_code);
    end

    // Update data bits and operator on a strobed command; defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            op_q   <= OP_OR;
        end else if (cmd_valid) begin
            case (act)
                ACT_LOAD: begin
                    data_q <= cmd_data;
                end
                ACT_LOAD_OR: begin
                    data_q <= cmd_data;
                    op_q   <= OP_OR;
                end
                ACT_LOAD_AND: begin
                    data_q <= cmd_data;
                    op_q   <= OP_AND;
                end
                default: begin
                end
            endcase
        end
    end

    // R4: operator-select codes set the operator and load the data.
    p_sel_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 4'b0011) |=>
            (op_q == OP_OR) && (data_q == $past(cmd_data)));

    p_sel_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 4'b1111) |=>
            (op_q == OP_AND) && (data_q == $past(cmd_data)));

    // R5: the three ignored codes leave the state untouched.
    p_ignore_codes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_code == 4'b0000 || cmd_code == 4'b1100 ||
                       cmd_code == 4'b1010)) |=>
            $stable(data_q) && $stable(op_q));

    // R6: unlisted codes load data and keep the operator.
    p_other_keep_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code != 4'b0000 && cmd_code != 4'b1100 &&
         cmd_code != 4'b1010 && cmd_code != 4'b0011 &&
         cmd_code != 4'b1111) |=>
            $stable(op_q) && (data_q == $past(cmd_data)));

    // R9: without a strobe the state holds.
    p_no_strobe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(data_q) && $stable(op_q));

endmodule

// File: rtl/gcmb_gate_mix.sv
`timescale 1ns/1ps
// Per-channel combining logic.
// Does: merges each synchronized active pin with its data bit under the
//       shared operator, then applies the thermal forced-off.
// Assumes: all inputs are already in the clk domain except therm_off,
//          which is applied without a register so shutdown is immediate.
module gcmb_gate_mix
    import gcmb_pkg::*;
#(
    parameter int N_CH = 4
) (
    input  logic [N_CH-1:0] act_sync,
    input  logic [N_CH-1:0] data_q,
    input  comb_op_t        op_q,
    input  logic [N_CH-1:0] therm_off,
    output logic [N_CH-1:0] gate_en
);

    genvar c;
    generate
        for (c = 0; c < N_CH; c++) begin : g_ch
            logic merged;
            // Combine pin and data bit for this channel, then gate by shutdown.
            always_comb begin
                if (op_q == OP_AND) merged = act_sync[c] & data_q[c];
                else                merged = act_sync[c] | data_q[c];
                gate_en[c] = merged & ~therm_off[c];
            end
        end
    endgenerate

endmodule

// File: rtl/chan_gate_combiner.sv
`timescale 1ns/1ps
// Polarity-programmable channel input combiner (top).
// Does: forms per-channel gate enables from parallel pins, strobed serial
//       data bits, a sticky OR/AND operator and thermal shutdown.
// Assumes: synchronous active-low reset; cmd_* come from a serial decoder in
//          the clk domain; pin_in and strap_hi are asynchronous.
module chan_gate_combiner
    import gcmb_pkg::*;
#(
    parameter int N_CH        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_hi,
    input  logic [N_CH-1:0]   pin_in,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [N_CH-1:0]   cmd_data,
    input  logic [N_CH-1:0]   therm_off,
    output logic [N_CH-1:0]   gate_en
);

    logic [N_CH-1:0] act_sync;
    logic [N_CH-1:0] data_q;
    comb_op_t        op_q;

    gcmb_pin_sync #(
        .WIDTH  (N_CH),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_hi (strap_hi),
        .pin_raw  (pin_in),
        .act_sync (act_sync)
    );

    gcmb_cmd_reg #(
        .N_CH (N_CH)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_data  (cmd_data),
        .data_q    (data_q),
        .op_q      (op_q)
    );

    gcmb_gate_mix #(
        .N_CH (N_CH)
    ) u_mix (
        .act_sync  (act_sync),
        .data_q    (data_q),
        .op_q      (op_q),
        .therm_off (therm_off),
        .gate_en   (gate_en)
    );

    // R8: a channel in shutdown never has its gate enabled.
    p_therm_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (therm_off & gate_en) == '0);

    // R1: the first cycle after reset release shows defaults: only active pins
    // may drive gates (data 0000 under OR), and freshly cleared sync stages.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gate_en == '0));

endmodule

// File: tb/chan_gate_combiner_bench.sv
`timescale 1ns/1ps
module chan_gate_combiner_bench;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         strap_hi = 1'b1;
    logic [N-1:0] pin_in = '0;
    logic         cmd_valid = 1'b0;
    logic [3:0]   cmd_code = '0;
    logic [N-1:0] cmd_data = '0;
    logic [N-1:0] therm_off = '0;
    logic [N-1:0] gate_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    chan_gate_combiner u_chan_gate_combiner (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_hi  (strap_hi),
        .pin_in    (pin_in),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_data  (cmd_data),
        .therm_off (therm_off),
        .gate_en   (gate_en)
    );

    function automatic logic [N-1:0] model(input bit is_and, input logic [N-1:0] d,
                                           input logic [N-1:0] p, input bit s,
                                           input logic [N-1:0] t);
        logic [N-1:0] a;
        a = s ? p : ~p;
        return (is_and ? (a & d) : (a | d)) & ~t;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [3:0] code, input logic [N-1:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 4'b0000; cmd_data = '0;
    endtask

    task automatic set_pins(input logic [N-1:0] p, input bit s);
        @(negedge clk);
        pin_in = p; strap_hi = s;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        // R1: gates off during reset, even with pins active.
        pin_in = 4'b1111; strap_hi = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 gates off in reset", gate_en, 4'b0000);
        rst_n = 1'b1;
        set_pins(4'b1010, 1'b1);
        check("R1 default OR with data 0000", gate_en, 4'b1010);

        // R2: two-edge latency, per-channel isolation.
        @(negedge clk);
        pin_in = 4'b0101;
        @(posedge clk); @(negedge clk);
        check("R2 unchanged after one edge", gate_en, 4'b1010);
        @(posedge clk); @(negedge clk);
        check("R2 changed after two edges", gate_en, 4'b0101);

        // R3 R4 R7 R8: exhaustive sweep.
        for (int op = 0; op < 2; op++) begin
            for (int d = 0; d < 16; d++) begin
                send_cmd(op == 1 ? 4'b1111 : 4'b0011, 4'(d));
                for (int s = 0; s < 2; s++) begin
                    for (int p = 0; p < 16; p++) begin
                        set_pins(4'(p), s[0]);
                        check("R7 R3 R4 sweep", gate_en,
                              model(op == 1, 4'(d), 4'(p), s[0], 4'b0000));
                        therm_off = 4'((p * 5 + d + s * 3) & 15);
                        #1;
                        check("R8 thermal force", gate_en,
                              model(op == 1, 4'(d), 4'(p), s[0], therm_off));
                        therm_off = '0;
                    end
                end
            end
        end

        // R5: ignored codes, starting from AND with data 0110.
        send_cmd(4'b1111, 4'b0110);
        send_cmd(4'b0000, 4'b1001);
        send_cmd(4'b1100, 4'b1001);
        send_cmd(4'b1010, 4'b1001);
        set_pins(4'b1111, 1'b1);
        check("R5 data bits kept", gate_en, 4'b0110);
        set_pins(4'b0000, 1'b1);
        check("R5 AND operator kept", gate_en, 4'b0000);

        // R6: unlisted code under AND loads data, keeps AND.
        send_cmd(4'b0101, 4'b1011);
        check("R6 AND kept on load", gate_en, 4'b0000);
        set_pins(4'b1111, 1'b1);
        check("R6 data loaded", gate_en, 4'b1011);
        // R6: unlisted code under OR keeps OR.
        send_cmd(4'b0011, 4'b0000);
        send_cmd(4'b0110, 4'b1100);
        set_pins(4'b0000, 1'b1);
        check("R6 OR kept on load", gate_en, 4'b1100);

        // R9: no strobe, state holds.
        @(negedge clk);
        cmd_code = 4'b1111; cmd_data = 4'b0011;
        repeat (3) @(negedge clk);
        cmd_code = 4'b0000; cmd_data = '0;
        check("R9 data and OR held without strobe", gate_en, 4'b1100);

        // R1: reset mid-run returns to OR / 0000.
        send_cmd(4'b1111, 4'b1111);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 gates off in mid-run reset", gate_en, 4'b0000);
        rst_n = 1'b1;
        set_pins(4'b0110, 1'b0);
        check("R1 defaults after mid-run reset", gate_en, 4'b1001);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule